// File: doc/BRIEF.md
# Port-Partitioned Oldest-First Issue Selector

This block chooses which scheduler entries issue in a cycle. Each entry carries a bid flag (it is ready), an age stamp and the identity of the execution port it was bound to when it entered the scheduler. For every port there is a separate 1-of-M selector. It looks only at the bidding entries bound to that port and grants the oldest of them. The machine therefore issues at most one instruction per port per cycle, and its issue width equals the port count.

Grants are purely combinational from the inputs, with no state. An entry that loses keeps its bid up and competes again in the next cycle. A ready instruction is never moved to a port it is not bound to. A port with no bound bidder stays idle while another port may hold several ready entries, so the overall issue order can be less than strictly oldest-first. The interface carries no stream, so every pin is a plain level signal with no valid/ready handshake and no back-pressure. The entry count must be a power of two.

Top module: `psel_top`

## Requirements
- R1: For each port p, the grant slice `gnt_o[p*NUM_ENTRIES +: NUM_ENTRIES]` has at most one bit set. Bit i of the slice grants entry i.
- R2: Port p grants entry i only if `bid_i[i]` is 1 and the entry's port field `port_i[i*PORT_W +: PORT_W]` equals p. With the defaults, PORT_W is 2.
- R3: If at least one bidding entry is bound to port p, port p grants exactly one entry in that cycle.
- R4: The entry granted on a port has an age, `age_i[i*AGE_W +: AGE_W]`, that is less than or equal to the age of every other bidder on that port. A smaller value means older. When the winner stops bidding, the next-oldest bidder on that port is granted.
- R5: When bidders on the same port have equal age, the grant goes to the lower entry index.
- R6: An entry with its bid low is never granted, whatever its age (including age 0) and whatever port it is bound to.
- R7: A port with no bound bidder grants nothing, even if other ports have several bidders at the same time.
- R8: Each entry is granted on at most one port per cycle.
- R9: The grant on one port does not depend on the bids, ages or bindings of entries bound to other ports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bid_i | input | NUM_ENTRIES | Per-entry ready bid |
| age_i | input | NUM_ENTRIES*AGE_W | Packed per-entry age, entry i at bits [i*AGE_W +: AGE_W], smaller is older |
| port_i | input | NUM_ENTRIES*PORT_W | Packed per-entry bound port id, entry i at bits [i*PORT_W +: PORT_W] |
| gnt_o | output | NUM_PORTS*NUM_ENTRIES | One grant slice per port, port p at bits [p*NUM_ENTRIES +: NUM_ENTRIES] |

## Verification
Two things can happen in the same cycle: one port holds several bidders and must reject the younger ones, while another port has no bound bidder and must stay idle. The bench sets up ready ages 2 and 3 on one port and age 4 on a second port, with the remaining ports empty. It requires a grant vector in which the age-2 and age-4 entries win, the age-3 entry waits, and the empty ports show all-zero slices. A later cycle drops the age-2 winner and checks that the age-3 entry is then granted. Tie-breaking and the masking of non-bidders are also checked by exact grant vectors, and a long pseudo-random sweep is compared against a simple scan model.

// File: rtl/psel_pkg.sv
package psel_pkg;

  localparam int DEF_ENTRIES = 16;
  localparam int DEF_PORTS   = 4;
  localparam int DEF_AGE_W   = 4;

  // Width of an index over n items, never below one bit.
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/psel_port_route.sv
// Splits the global bid vector into one request vector per port,
// according to the port each entry was bound to at dispatch.
module psel_port_route #(
  parameter int M  = psel_pkg::DEF_ENTRIES,
  parameter int P  = psel_pkg::DEF_PORTS,
  parameter int PW = psel_pkg::idx_bits(psel_pkg::DEF_PORTS)
) (
  input  logic [M-1:0]    bid_i,
  input  logic [M*PW-1:0] port_i,
  output logic [P*M-1:0]  req_o
);

  for (genvar p = 0; p < P; p++) begin : g_port
    for (genvar i = 0; i < M; i++) begin : g_ent
      assign req_o[p*M + i] = bid_i[i] && (port_i[i*PW +: PW] == PW'(p));
    end
  end

endmodule

// File: rtl/psel_age_tree.sv
// 1-of-M oldest-first selector built as a balanced tournament tree.
// Nodes are stored heap-style: node 0 is the root, and the leaves sit at
// M-1 .. 2M-2 in entry order, so a left child always covers lower indices.
module psel_age_tree #(
  parameter int M  = psel_pkg::DEF_ENTRIES,
  parameter int AW = psel_pkg::DEF_AGE_W
) (
  input  logic [M-1:0]    req_i,
  input  logic [M*AW-1:0] age_i,
  output logic [M-1:0]    gnt_o
);

  localparam int IW    = psel_pkg::idx_bits(M);
  localparam int NODES = 2*M - 1;

  logic [NODES-1:0]         nd_vld;
  logic [NODES-1:0][AW-1:0] nd_age;
  logic [NODES-1:0][IW-1:0] nd_idx;

  for (genvar i = 0; i < M; i++) begin : g_leaf
    assign nd_vld[M-1+i] = req_i[i];
    assign nd_age[M-1+i] = age_i[i*AW +: AW];
    assign nd_idx[M-1+i] = IW'(i);
  end

  for (genvar k = 0; k < M-1; k++) begin : g_node
    logic take_left;
    // Left wins on an age tie, which favours the lower entry index.
    assign take_left = nd_vld[2*k+1] &&
                       (!nd_vld[2*k+2] || (nd_age[2*k+1] <= nd_age[2*k+2]));
    assign nd_vld[k] = nd_vld[2*k+1] || nd_vld[2*k+2];
    assign nd_age[k] = take_left ? nd_age[2*k+1] : nd_age[2*k+2];
    assign nd_idx[k] = take_left ? nd_idx[2*k+1] : nd_idx[2*k+2];
  end

  always_comb begin
    gnt_o = '0;
    if (nd_vld[0]) gnt_o[nd_idx[0]] = 1'b1;
  end

endmodule

// File: rtl/psel_top.sv
// Port-partitioned oldest-first issue selector: one independent age tree
// per execution port, each seeing only the entries bound to it.
module psel_top #(
  parameter int NUM_ENTRIES = psel_pkg::DEF_ENTRIES,
  parameter int NUM_PORTS   = psel_pkg::DEF_PORTS,
  parameter int AGE_W       = psel_pkg::DEF_AGE_W,
  parameter int PORT_W      = psel_pkg::idx_bits(NUM_PORTS)
) (
  input  logic [NUM_ENTRIES-1:0]        bid_i,
  input  logic [NUM_ENTRIES*AGE_W-1:0]  age_i,
  input  logic [NUM_ENTRIES*PORT_W-1:0] port_i,
  output logic [NUM_PORTS*NUM_ENTRIES-1:0] gnt_o
);

  localparam int GW = NUM_PORTS * NUM_ENTRIES;

  logic [GW-1:0] port_req;

  psel_port_route #(
    .M  (NUM_ENTRIES),
    .P  (NUM_PORTS),
    .PW (PORT_W)
  ) u_route (
    .bid_i  (bid_i),
    .port_i (port_i),
    .req_o  (port_req)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_sel
    psel_age_tree #(
      .M  (NUM_ENTRIES),
      .AW (AGE_W)
    ) u_tree (
      .req_i (port_req[p*NUM_ENTRIES +: NUM_ENTRIES]),
      .age_i (age_i),
      .gnt_o (gnt_o[p*NUM_ENTRIES +: NUM_ENTRIES])
    );
  end

endmodule

// File: rtl/psel_chk.sv
// Property checker for psel_top; attached with the bind below.
module psel_chk #(
  parameter int M  = psel_pkg::DEF_ENTRIES,
  parameter int P  = psel_pkg::DEF_PORTS,
  parameter int AW = psel_pkg::DEF_AGE_W,
  parameter int PW = psel_pkg::idx_bits(psel_pkg::DEF_PORTS)
) (
  input logic [M-1:0]    bid_i,
  input logic [M*AW-1:0] age_i,
  input logic [M*PW-1:0] port_i,
  input logic [P*M-1:0]  gnt_o
);

  logic [P-1:0][M-1:0] on_port;
  logic [M-1:0][P-1:0] per_ent;

  for (genvar p = 0; p < P; p++) begin : g_map
    for (genvar i = 0; i < M; i++) begin : g_e
      assign on_port[p][i] = bid_i[i] && (port_i[i*PW +: PW] == PW'(p));
      assign per_ent[i][p] = gnt_o[p*M + i];
    end
  end

  for (genvar p = 0; p < P; p++) begin : g_port
    always_comb begin
      // R1
      one_grant_chk: assert ($onehot0(gnt_o[p*M +: M]));
      // R2
      bound_grant_chk: assert ((gnt_o[p*M +: M] & ~on_port[p]) == '0);
      // R3
      busy_port_chk: assert (!(|on_port[p]) || (|gnt_o[p*M +: M]));
      // R7
      idle_port_chk: assert ((|on_port[p]) || (gnt_o[p*M +: M] == '0));
    end

    for (genvar i = 0; i < M; i++) begin : g_win
      always_comb begin
        if (gnt_o[p*M + i]) begin
          for (int j = 0; j < M; j++) begin
            if (on_port[p][j]) begin
              // R4
              oldest_win_chk: assert (age_i[i*AW +: AW] <= age_i[j*AW +: AW]);
              // R5
              tie_low_chk: assert ((age_i[i*AW +: AW] != age_i[j*AW +: AW]) || (i <= j));
            end
          end
        end
      end
    end
  end

  for (genvar i = 0; i < M; i++) begin : g_ent
    always_comb begin
      // R8
      single_port_chk: assert ($countones(per_ent[i]) <= 1);
      // R6
      no_bid_chk: assert (bid_i[i] || (per_ent[i] == '0));
    end
  end

endmodule

bind psel_top psel_chk #(
  .M  (NUM_ENTRIES),
  .P  (NUM_PORTS),
  .AW (AGE_W),
  .PW (PORT_W)
) u_psel_chk (
  .bid_i  (bid_i),
  .age_i  (age_i),
  .port_i (port_i),
  .gnt_o  (gnt_o)
);

// File: tb/test_psel_top.sv
module test_psel_top;

  localparam int M  = 16;
  localparam int P  = 4;
  localparam int AW = 4;
  localparam int PW = 2;
  localparam int GW = P*M;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [M-1:0]    bid = '0;
  logic [M*AW-1:0] age = '1;
  logic [M*PW-1:0] prt = '0;
  logic [GW-1:0]   gnt;

  int total = 0;
  int bad   = 0;
  logic [31:0] rs = 32'h1F2E_3D4C;

  psel_top i_psel_top (
    .bid_i  (bid),
    .age_i  (age),
    .port_i (prt),
    .gnt_o  (gnt)
  );

  function automatic logic [GW-1:0] g(input int p, input int i);
    logic [GW-1:0] v = '0;
    v[p*M + i] = 1'b1;
    return v;
  endfunction

  // Scan model: per port, the first strictly smallest age among bidders.
  function automatic logic [GW-1:0] model();
    logic [GW-1:0] e = '0;
    for (int p = 0; p < P; p++) begin
      int best = -1;
      for (int i = 0; i < M; i++) begin
        if (bid[i] && int'(prt[i*PW +: PW]) == p) begin
          if (best < 0 || age[i*AW +: AW] < age[best*AW +: AW]) best = i;
        end
      end
      if (best >= 0) e[p*M + best] = 1'b1;
    end
    return e;
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic clear_all();
    bid = '0;
    age = '1;
    prt = '0;
  endtask

  task automatic set_e(input int i, input bit b, input int a, input int p);
    bid[i]            = b;
    age[i*AW +: AW]   = AW'(a);
    prt[i*PW +: PW]   = PW'(p);
  endtask

  task automatic chk(input string req, input logic [GW-1:0] exp);
    #2;
    total++;
    if (gnt !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, gnt, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    clear_all();
    chk("R7 idle after reset", '0);
  endtask

  task automatic t_single();
    @(negedge clk);
    clear_all();
    set_e(3, 1, 9, 0);
    set_e(6, 1, 1, 1);
    set_e(10, 1, 15, 2);
    set_e(15, 1, 7, 3);
    chk("R2 R3 one bidder per port", g(0,3) | g(1,6) | g(2,10) | g(3,15));
  endtask

  task automatic t_oldest();
    @(negedge clk);
    clear_all();
    set_e(1, 1, 9, 2);
    set_e(8, 1, 3, 2);
    set_e(13, 1, 7, 2);
    chk("R4 oldest on port", g(2,8));
    @(negedge clk);
    set_e(8, 0, 3, 2);
    chk("R4 loser bids again", g(2,13));
  endtask

  task automatic t_tie();
    @(negedge clk);
    clear_all();
    set_e(12, 1, 5, 1);
    set_e(5, 1, 5, 1);
    set_e(9, 1, 6, 1);
    chk("R5 tie to lower index", g(1,5));
  endtask

  task automatic t_nobid();
    @(negedge clk);
    clear_all();
    set_e(0, 0, 0, 3);
    set_e(7, 1, 14, 3);
    chk("R6 non-bidder age 0", g(3,7));
    @(negedge clk);
    set_e(7, 0, 14, 3);
    chk("R6 all low", '0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    clear_all();
    set_e(2, 1, 2, 0);
    set_e(4, 1, 3, 0);
    set_e(11, 1, 4, 1);
    chk("R7 no promotion to idle port", g(0,2) | g(1,11));
    @(negedge clk);
    set_e(2, 0, 2, 0);
    chk("R4 waiting entry issues next", g(0,4) | g(1,11));
  endtask

  task automatic t_indep();
    @(negedge clk);
    clear_all();
    set_e(6, 1, 8, 0);
    set_e(9, 1, 10, 0);
    set_e(1, 1, 12, 1);
    chk("R9 base", g(0,6) | g(1,1));
    @(negedge clk);
    set_e(1, 1, 0, 1);
    set_e(14, 1, 0, 1);
    set_e(3, 1, 1, 2);
    chk("R9 other ports changed", g(0,6) | g(1,1) | g(2,3));
  endtask

  task automatic t_sweep();
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      rs = nxt(rs);
      bid = rs[15:0];
      rs = nxt(rs);
      prt = rs;
      rs = nxt(rs);
      age[31:0] = rs;
      rs = nxt(rs);
      age[63:32] = rs;
      if (n % 7 == 0) age[63:32] = age[31:0];
      chk("R1 R3 R4 R8 sweep", model());
    end
  endtask

  initial begin
    #(8*200000);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_oldest();
    t_tie();
    t_nobid();
    t_idle();
    t_indep();
    t_sweep();
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule